// File: doc/BRIEF.md
# Transform-Block Edge Classifier

This block decides, for every 4x4 block of transform coefficients in an image, whether that block is an edge block. The activity of a block is the mean magnitude of its fifteen AC coefficients, and a block counts as an edge block when its activity is strictly greater than a fraction `tau` of the largest activity found anywhere in the image. Every block has the same number of AC coefficients, so comparing means is the same as comparing sums. The block therefore works on exact integer sums and needs no divider.

The threshold depends on an image-wide maximum, so the caller streams the image twice. A start pulse latches the block count and `tau`, and clears the running maximum. During the first pass the coefficient stream only updates that maximum. Once the last block of the first pass has been summed, `second_pass` rises. The caller then streams the same blocks again, and the block returns one edge flag per block, in stream order. A `done` pulse marks the final flag.

Each block is framed by a start-of-block marker on its DC coefficient. The DC value is discarded, and the next fifteen accepted coefficients form the block's AC set.

Top module: `edge_classifier`

## Requirements
- R1: A coefficient with `coef_valid` and `coef_sob` high opens a block, and that coefficient is treated as DC. The block closes on the fifteenth valid coefficient after it that has `coef_sob` low. Valid coefficients that arrive while no block is open, or while the unit is idle, change no block sum.
- R2: A block's activity sum is the sum of the absolute values of its fifteen AC coefficients, taken as signed two's complement of width `CW`. The DC value is excluded. The most negative code counts as magnitude 2^(CW-1).
- R3: `start` while idle clears the running maximum and latches `block_count` and `tau`. `start` while busy is ignored. Changes to `tau` after the start pulse have no effect on that run.
- R4: During the first pass no flag is emitted. After `block_count` blocks have closed, `second_pass` goes high.
- R5: In the second pass, each closed block produces exactly one `flag_valid` pulse, in input order. `flag_edge` is 1 if and only if 256*sum > tau*max, where `tau` is an unsigned fraction with 8 fractional bits. The comparison is strict, so a block exactly at the threshold is not an edge.
- R6: When every block has an activity sum of zero, no block is flagged as an edge.
- R7: `done` is high for one cycle, together with the last flag of the second pass, and `busy` is low on the following cycle. A start with `block_count` of zero gives a single `done` pulse one cycle after `start`, with no flags.
- R8: A `coef_sob` that arrives inside an open block abandons the partial sum and reopens the block from that coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new image (first pass) |
| block_count | input | CNT_W | Number of blocks in the image |
| tau | input | TAU_W | Threshold fraction, unsigned, TAU_W fractional bits |
| coef_valid | input | 1 | Coefficient on `coef_data` is valid |
| coef_sob | input | 1 | Marks the DC coefficient that opens a block |
| coef_data | input | CW | Signed coefficient |
| busy | output | 1 | A run is in progress |
| second_pass | output | 1 | Unit is in the classifying pass |
| flag_valid | output | 1 | `flag_edge` carries a block decision |
| flag_edge | output | 1 | 1 when the block is an edge block |
| done | output | 1 | Last decision of the run, or end of an empty run |

## Verification
The hardest case to reach from the ports is the threshold boundary. Here the product of `tau` and the maximum must equal 256 times a block sum exactly, and the only way to steer the sums is through coefficient magnitudes. The stimulus sets the maximum block to fifteen coefficients of magnitude 2 and the other blocks to sums of 15 and 16 at half scale. It also makes the most negative code the maximum at `tau` = 255, so that a block summing to 2040 sits exactly on the threshold. Framing noise is checked by adding stray coefficients and an early restart of block 0 in both passes. The expected flags must stay unchanged under that noise.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_MARK  = 2'd2,
      ST_DRAIN = 2'd3
   } ecl_state_e;
endpackage

// File: rtl/ecl_block_accum.sv
module ecl_block_accum #(
   parameter int CW    = 12,
   parameter int COEFS = 16,
   parameter int IDX_W = 4,
   parameter int SUM_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic                 coef_valid,
   input  logic                 coef_sob,
   input  logic signed [CW-1:0] coef_data,
   output logic                 sum_valid,
   output logic [SUM_W-1:0]     sum
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COEFS - 1);
   localparam longint MAX_SUM = longint'(COEFS - 1) * (longint'(1) << (CW - 1));

   logic [IDX_W-1:0] idx;
   logic             in_blk;
   logic [SUM_W-1:0] acc;
   logic [CW-1:0]    mag;
   logic [SUM_W-1:0] mag_ext;
   logic             take;

   always_comb begin
      mag     = coef_data[CW-1] ? CW'(-coef_data) : CW'(coef_data);
      mag_ext = SUM_W'(mag);
      take    = en && coef_valid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx       <= '0;
         in_blk    <= 1'b0;
         acc       <= '0;
         sum       <= '0;
         sum_valid <= 1'b0;
      end else begin
         sum_valid <= 1'b0;
         if (clr) begin
            idx    <= '0;
            in_blk <= 1'b0;
            acc    <= '0;
         end else if (take) begin
            if (coef_sob) begin
               in_blk <= 1'b1;
               idx    <= IDX_W'(1);
               acc    <= '0;
            end else if (in_blk) begin
               if (idx == LAST_IDX) begin
                  sum       <= acc + mag_ext;
                  sum_valid <= 1'b1;
                  in_blk    <= 1'b0;
                  idx       <= '0;
               end else begin
                  acc <= acc + mag_ext;
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   end

   // R1
   sum_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_valid |-> $past(en && coef_valid && !coef_sob));

   // R2
   sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_valid |-> (longint'(sum) <= MAX_SUM));
endmodule

// File: rtl/ecl_ctrl.sv
module ecl_ctrl
   import ecl_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int TAU_W = 8,
   parameter int SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] block_count,
   input  logic [TAU_W-1:0] tau_in,
   input  logic             sum_valid,
   input  logic [SUM_W-1:0] sum,
   input  logic             last_out,
   output logic             busy,
   output logic             second_pass,
   output logic             acc_clr,
   output logic             acc_en,
   output logic             cmp_valid,
   output logic             cmp_last,
   output logic [SUM_W-1:0] max_q,
   output logic [TAU_W-1:0] tau_q,
   output logic             zero_done
);
   ecl_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             at_last;
   logic             idle_start;

   always_comb begin
      idle_start  = (state == ST_IDLE) && start;
      at_last     = (cnt == lim - CNT_W'(1));
      busy        = (state != ST_IDLE);
      second_pass = (state == ST_MARK) || (state == ST_DRAIN);
      acc_clr     = idle_start;
      acc_en      = (state == ST_SCAN) || (state == ST_MARK);
      cmp_valid   = (state == ST_MARK) && sum_valid;
      cmp_last    = at_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         lim       <= '0;
         max_q     <= '0;
         tau_q     <= '0;
         zero_done <= 1'b0;
      end else begin
         zero_done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               lim   <= block_count;
               tau_q <= tau_in;
               max_q <= '0;
               cnt   <= '0;
               if (block_count == '0) zero_done <= 1'b1;
               else                   state     <= ST_SCAN;
            end
            ST_SCAN: if (sum_valid) begin
               if (sum > max_q) max_q <= sum;
               if (at_last) begin
                  cnt   <= '0;
                  state <= ST_MARK;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_MARK: if (sum_valid) begin
               if (at_last) state <= ST_DRAIN;
               else         cnt   <= cnt + 1'b1;
            end
            ST_DRAIN: if (last_out) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3
   busy_start_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (second_pass && start) |=> (state != ST_SCAN));

   // R3
   scan_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCAN && start && !sum_valid) |=> $stable(cnt) && $stable(max_q));

   // R4
   max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCAN && $past(state) == ST_SCAN) |-> (max_q >= $past(max_q)));
endmodule

// File: rtl/ecl_cmp.sv
module ecl_cmp #(
   parameter int SUM_W = 16,
   parameter int TAU_W = 8,
   parameter int PIPE  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [SUM_W-1:0] sum,
   input  logic [SUM_W-1:0] max_v,
   input  logic [TAU_W-1:0] tau,
   output logic             out_valid,
   output logic             out_edge,
   output logic             out_last
);
   localparam int PW = SUM_W + TAU_W;

   logic [PW-1:0] lhs;
   logic [PW-1:0] rhs;

   always_comb begin
      lhs = {sum, {TAU_W{1'b0}}};
      rhs = PW'(tau) * PW'(max_v);
   end

   generate
      if (PIPE == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_edge  <= 1'b0;
               out_last  <= 1'b0;
            end else begin
               out_valid <= in_valid;
               out_edge  <= in_valid && (lhs > rhs);
               out_last  <= in_valid && in_last;
            end
         end
      end else begin : g_staged
         logic [PW-1:0] lhs_q;
         logic [PW-1:0] rhs_q;
         logic          v_q;
         logic          l_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lhs_q     <= '0;
               rhs_q     <= '0;
               v_q       <= 1'b0;
               l_q       <= 1'b0;
               out_valid <= 1'b0;
               out_edge  <= 1'b0;
               out_last  <= 1'b0;
            end else begin
               lhs_q     <= lhs;
               rhs_q     <= rhs;
               v_q       <= in_valid;
               l_q       <= in_valid && in_last;
               out_valid <= v_q;
               out_edge  <= v_q && (lhs_q > rhs_q);
               out_last  <= l_q;
            end
         end
      end
   endgenerate

   // R5
   last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
endmodule

// File: rtl/edge_classifier.sv
module edge_classifier
   import ecl_pkg::*;
#(
   parameter int CW       = 12,
   parameter int DIM      = 4,
   parameter int CNT_W    = 10,
   parameter int TAU_W    = 8,
   parameter int CMP_PIPE = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CNT_W-1:0]     block_count,
   input  logic [TAU_W-1:0]     tau,
   input  logic                 coef_valid,
   input  logic                 coef_sob,
   input  logic signed [CW-1:0] coef_data,
   output logic                 busy,
   output logic                 second_pass,
   output logic                 flag_valid,
   output logic                 flag_edge,
   output logic                 done
);
   localparam int COEFS = DIM * DIM;
   localparam int IDX_W = $clog2(COEFS);
   localparam int SUM_W = CW + IDX_W;

   generate
      if (CW < 2) begin : g_bad_cw
         $error("edge_classifier: CW must be at least 2");
      end
      if (DIM < 2) begin : g_bad_dim
         $error("edge_classifier: DIM must be at least 2");
      end
      if (CMP_PIPE < 0 || CMP_PIPE > 1) begin : g_bad_pipe
         $error("edge_classifier: CMP_PIPE must be 0 or 1");
      end
      if (TAU_W < 1) begin : g_bad_tau
         $error("edge_classifier: TAU_W must be at least 1");
      end
   endgenerate

   logic             acc_clr;
   logic             acc_en;
   logic             sum_valid;
   logic [SUM_W-1:0] sum;
   logic             cmp_valid;
   logic             cmp_last;
   logic [SUM_W-1:0] max_q;
   logic [TAU_W-1:0] tau_q;
   logic             zero_done;
   logic             out_last;

   ecl_block_accum #(
      .CW(CW), .COEFS(COEFS), .IDX_W(IDX_W), .SUM_W(SUM_W)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
      .coef_valid(coef_valid), .coef_sob(coef_sob), .coef_data(coef_data),
      .sum_valid(sum_valid), .sum(sum)
   );

   ecl_ctrl #(
      .CNT_W(CNT_W), .TAU_W(TAU_W), .SUM_W(SUM_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .block_count(block_count),
      .tau_in(tau), .sum_valid(sum_valid), .sum(sum),
      .last_out(flag_valid && out_last),
      .busy(busy), .second_pass(second_pass), .acc_clr(acc_clr),
      .acc_en(acc_en), .cmp_valid(cmp_valid), .cmp_last(cmp_last),
      .max_q(max_q), .tau_q(tau_q), .zero_done(zero_done)
   );

   ecl_cmp #(
      .SUM_W(SUM_W), .TAU_W(TAU_W), .PIPE(CMP_PIPE)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .in_valid(cmp_valid), .in_last(cmp_last),
      .sum(sum), .max_v(max_q), .tau(tau_q),
      .out_valid(flag_valid), .out_edge(flag_edge), .out_last(out_last)
   );

   assign done = (flag_valid && out_last) || zero_done;

   // R4
   scan_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !second_pass) |-> !flag_valid);

   // R5
   flag_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_valid |-> second_pass);

   // R6
   zero_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_valid && max_q == '0) |-> !flag_edge);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_valid && out_last) |=> !busy);
endmodule

// File: tb/edge_classifier_bench.sv
module edge_classifier_bench;
   localparam int CW = 12;
   localparam int CNT_W = 10;
   localparam int TAU_W = 8;
   localparam int MAXB = 16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [CNT_W-1:0]     block_count = '0;
   logic [TAU_W-1:0]     tau = '0;
   logic                 coef_valid = 1'b0;
   logic                 coef_sob = 1'b0;
   logic signed [CW-1:0] coef_data = '0;
   logic busy, second_pass, flag_valid, flag_edge, done;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int ngot = 0;
   int ndone = 0;
   bit got [0:MAXB-1];
   int blk [0:MAXB-1][0:15];

   edge_classifier u_edge_classifier (
      .clk(clk), .rst_n(rst_n), .start(start), .block_count(block_count),
      .tau(tau), .coef_valid(coef_valid), .coef_sob(coef_sob),
      .coef_data(coef_data), .busy(busy), .second_pass(second_pass),
      .flag_valid(flag_valid), .flag_edge(flag_edge), .done(done)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (flag_valid) begin
            if (ngot < MAXB) got[ngot] = flag_edge;
            ngot = ngot + 1;
         end
         if (done) ndone = ndone + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint bsum(input int b);
      longint s = 0;
      for (int i = 1; i < 16; i++) s += (blk[b][i] < 0) ? -blk[b][i] : blk[b][i];
      return s;
   endfunction

   task automatic fill(input int b, input int dc, input int ac);
      blk[b][0] = dc;
      for (int i = 1; i < 16; i++) blk[b][i] = ac;
   endtask

   task automatic send_coef(input bit sob, input int v);
      @(negedge clk);
      coef_valid = 1'b1;
      coef_sob   = sob;
      coef_data  = CW'(v);
   endtask

   task automatic idle_cycle;
      @(negedge clk);
      coef_valid = 1'b0;
      coef_sob   = 1'b0;
   endtask

   task automatic send_block(input int b, input bit noisy);
      if (noisy) begin
         // R1 stray coefficients outside any block, R8 restarted partial block
         send_coef(1'b0, 2000);
         send_coef(1'b0, -1500);
         send_coef(1'b1, 100);
         for (int i = 0; i < 5; i++) send_coef(1'b0, 1900);
      end
      for (int i = 0; i < 16; i++) send_coef(i == 0, blk[b][i]);
      idle_cycle();
   endtask

   task automatic run_image(input string tag, input int n, input int t, input int t_after,
                            input bit glitch, input bit noisy);
      longint mx = 0;
      bit exp_f [0:MAXB-1];
      for (int b = 0; b < n; b++) if (bsum(b) > mx) mx = bsum(b);
      for (int b = 0; b < n; b++) exp_f[b] = (bsum(b) * 256) > (longint'(t) * mx);
      ngot = 0;
      ndone = 0;
      @(negedge clk);
      start = 1'b1;
      block_count = CNT_W'(n);
      tau = TAU_W'(t);
      @(negedge clk);
      start = 1'b0;
      tau = TAU_W'(t_after);
      for (int b = 0; b < n; b++) begin
         send_block(b, noisy && b == 0);
         if (glitch && b == 0) begin
            @(negedge clk);
            start = 1'b1;
            block_count = CNT_W'(1);
            @(negedge clk);
            start = 1'b0;
         end
      end
      repeat (4) @(negedge clk);
      #1;
      chk(second_pass == 1'b1, "R4", {tag, " second pass entered"}, second_pass, 1);
      chk(ngot == 0, "R4", {tag, " no flags in first pass"}, ngot, 0);
      for (int b = 0; b < n; b++) send_block(b, noisy && b == 0);
      for (int w = 0; w < 30 && ndone == 0; w++) begin
         @(negedge clk);
         #1;
      end
      chk(ndone == 1, "R7", {tag, " one done pulse"}, ndone, 1);
      chk(ngot == n, "R5", {tag, " flag count"}, ngot, n);
      for (int b = 0; b < n && b < ngot; b++)
         chk(got[b] == exp_f[b], "R5", $sformatf("%s flag of block %0d", tag, b),
             got[b], exp_f[b]);
      @(negedge clk);
      #1;
      chk(busy == 1'b0, "R7", {tag, " idle after done"}, busy, 0);
      chk(ndone == 1, "R7", {tag, " done lasted one pulse"}, ndone, 1);
   endtask

   task automatic t_reset;
      chk(busy == 1'b0, "R7", "reset busy", busy, 0);
      chk(flag_valid == 1'b0, "R5", "reset flag_valid", flag_valid, 0);
      chk(done == 1'b0, "R7", "reset done", done, 0);
      chk(second_pass == 1'b0, "R4", "reset second_pass", second_pass, 0);
   endtask

   task automatic t_basic;
      fill(0, 300, 5);  fill(1, -40, 20);
      fill(2, 0, -12);  fill(3, 7, 1);
      blk[1][7] = -100;
      run_image("basic", 4, 128, 128, 1'b0, 1'b0);
   endtask

   task automatic t_dc_excluded;
      // R2: huge DC with zero AC is not active at tau 0
      fill(0, 2047, 0); fill(1, -2048, 0); fill(2, 0, 1);
      run_image("R2 dc", 3, 0, 0, 1'b0, 1'b0);
      chk(ngot == 3 && got[0] == 0 && got[1] == 0 && got[2] == 1, "R2",
          "dc-only blocks not flagged", ngot, 3);
   endtask

   task automatic t_threshold;
      // R5: max 30, sum 15 equals threshold at tau 128, sum 16 exceeds it
      fill(0, 0, 2); fill(1, 9, 1); fill(2, 9, 1);
      blk[2][15] = -2;
      run_image("R5 strict", 3, 128, 128, 1'b0, 1'b0);
      chk(ngot == 3 && got[1] == 0 && got[2] == 1, "R5",
          "equal not edge, one above is edge", got[1], 0);
   endtask

   task automatic t_most_negative;
      // R2: -2048 counts as 2048, block 2 sits on 255/256 of it
      fill(0, 0, 0); blk[0][5] = -2048;
      fill(1, 0, 0); blk[1][9] = 2047;
      fill(2, 0, 0); blk[2][3] = 2040;
      run_image("R2 negmax", 3, 255, 255, 1'b0, 1'b0);
      chk(ngot == 3 && got[0] == 1 && got[1] == 1 && got[2] == 0, "R2",
          "most negative magnitude", got[2], 0);
   endtask

   task automatic t_all_zero;
      for (int b = 0; b < 5; b++) fill(b, 50 * b, 0);
      run_image("R6 zero", 5, 0, 0, 1'b0, 1'b0);
      for (int b = 0; b < 5 && b < ngot; b++)
         chk(got[b] == 0, "R6", "zero activity not flagged", got[b], 0);
   endtask

   task automatic t_busy_start;
      // R3: start mid-run and a tau change after start are ignored
      for (int b = 0; b < 6; b++) fill(b, 0, b * 3);
      run_image("R3 busy", 6, 160, 10, 1'b1, 1'b0);
   endtask

   task automatic t_noisy;
      // R1 and R8: framing noise on block 0 in both passes
      fill(0, 1, 4); fill(1, 1, 8); fill(2, 1, 3);
      run_image("R8 noisy", 3, 100, 100, 1'b0, 1'b1);
   endtask

   task automatic t_zero_count;
      // R7: empty image
      ngot = 0;
      ndone = 0;
      @(negedge clk);
      start = 1'b1;
      block_count = '0;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(done == 1'b1, "R7", "empty run done one cycle after start", done, 1);
      repeat (3) @(negedge clk);
      #1;
      chk(ndone == 1, "R7", "empty run single done", ndone, 1);
      chk(ngot == 0, "R7", "empty run no flags", ngot, 0);
      chk(busy == 1'b0, "R7", "empty run stays idle", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_basic();
      t_dc_excluded();
      t_threshold();
      t_most_negative();
      t_all_zero();
      t_busy_start();
      t_noisy();
      t_zero_count();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule